// File: doc/BRIEF.md
# Flash and Torch Mode Controller

This block turns the LED driver's command register into an effective operating mode: off, idle, torch (steady low current) or flash (high current). It also runs the flash-duration budget. A flash draws current only while the command arms it and the external trigger pin is high. The remaining budget counts down in 100 ms ticks, but only while the flash is actually lit. It freezes while the pin is low. Each write to the command register reloads the budget, so software can stretch a flash beyond its maximum by rewriting the register before the budget runs out.

The register file sits outside this block. It passes in the current command value with a one-cycle write strobe, together with the torch and flash current fields from the dimming register. The block returns:
- the mode;
- a current-table step index;
- an enable for the thermistor divider;
- a one-cycle expiry event, which doubles as the request to clear the trigger-enable bit;
- a level that holds the dimming and auxiliary registers cleared while the part is off.

A forced-idle input from the status logic stops all light at once. The stop persists until the command register is written again. All pins are plain control and status levels or pulses. There is no streamed data, so no valid/ready handshake applies.

Top module: `flash_mode_ctrl`

## Requirements
- R1: The command byte holds power in bit 7, trigger-enable in bit 6, torch-on in bit 5, thermistor-on in bit 4 and the flash budget in bits 3:0. The mode output encodes off=0, idle=1, torch=2 and flash=3. The decode is: power 0 gives off; power 1 with trigger-enable 1 gives flash (or idle while not lit); power 1, trigger-enable 0 and torch-on 1 gives torch; power 1 with both of those bits 0 gives idle.
- R2: Flash mode is reported only while the trigger pin is high, trigger-enable is in effect and budget remains. With the pin low, an armed command reports idle.
- R3: After reset the mode is off until the first command write, whatever the command value is. While the mode is off, the clear output for the dimming and auxiliary registers is 1 and the step index is 0.
- R4: A write loads the 4-bit budget. The flash stays lit for exactly that many ticks of lit time. A budget of 0 never lights the flash.
- R5: When the budget runs out, the flash ends and the expiry event and trigger-enable clear pulse for exactly one cycle. The cycle after the last tick, trigger-enable is treated as 0, so a command with torch-on set then shows torch.
- R6: While the trigger pin is low, the budget neither decreases nor expires, even when ticks arrive. Lighting resumes with the remaining budget.
- R7: A command write reloads the budget and re-enables a flash that has expired, so the total lit time can exceed one budget.
- R8: The thermistor enable is 1 whenever the mode is torch or flash. Otherwise it equals the thermistor-on bit once a command has been written.
- R9: In torch mode the step index equals the 3-bit torch field (0..7). In flash mode it equals the 3-bit flash field plus 5 (5..12). In every other mode it is 0.
- R10: Torch has no time limit: ticks never end it. Writing torch-on 0 with power 1 gives idle.
- R11: While forced-idle is high, the mode is never torch or flash. After it falls, torch and flash stay off until the next command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_val | input | 8 | Current command register value |
| cmd_wr | input | 1 | One-cycle strobe in the cycle a new command value appears |
| tdim_val | input | 3 | Torch current field of the dimming register |
| fdim_val | input | 3 | Flash current field of the dimming register |
| trig_pin | input | 1 | External flash trigger pin |
| tick_100ms | input | 1 | One-cycle pulse every 100 ms |
| force_ready | input | 1 | Forced-idle request from the status logic |
| mode | output | 2 | Effective mode: 0 off, 1 idle, 2 torch, 3 flash |
| step_idx | output | 4 | Index into the 13-entry LED current table |
| ntc_en | output | 1 | Thermistor divider enable |
| timeout_evt | output | 1 | One-cycle flash budget expiry event |
| clr_trig_en | output | 1 | One-cycle request to clear the trigger-enable bit |
| clr_dim_aux | output | 1 | Holds the dimming and auxiliary registers cleared |

## Verification
The assertions check the following on every cycle:
- flash is never reported with the pin low or with no budget left;
- lit modes always enable the thermistor divider;
- forced-idle never coexists with light;
- the expiry pulse lasts one cycle and coincides with leaving flash;
- the budget holds while the pin is low.

Only the bench scenarios can show the rest:
- the exact number of lit ticks before expiry;
- that the budget survives a paused trigger;
- that a rewrite extends a flash or revives an expired one;
- the fall to torch after expiry;
- the full decode and current-step table.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_TORCH = 2'd2,
    MODE_FLASH = 2'd3
  } fm_mode_e;

  // Positions of the flag bits inside the 4-bit control nibble (command top bits).
  localparam int CTL_PWR  = 3;
  localparam int CTL_TRIG = 2;
  localparam int CTL_TCH  = 1;
  localparam int CTL_NTC  = 0;
endpackage

// File: rtl/fm_flash_timer.sv
module fm_flash_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [TW-1:0] ftim,
  input  logic          force_ready,
  input  logic          tick,
  input  logic          flash_lit,
  output logic [TW-1:0] remain,
  output logic          flash_kill,
  output logic          torch_kill,
  output logic          cmd_seen,
  output logic          expire
);
  localparam logic [TW-1:0] ONE = TW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain     <= '0;
      flash_kill <= 1'b1;
      torch_kill <= 1'b1;
      cmd_seen   <= 1'b0;
      expire     <= 1'b0;
    end else begin
      expire   <= 1'b0;
      cmd_seen <= cmd_seen | cmd_wr;
      if (force_ready) begin
        flash_kill <= 1'b1;
        torch_kill <= 1'b1;
      end else if (cmd_wr) begin
        remain     <= ftim;
        flash_kill <= 1'b0;
        torch_kill <= 1'b0;
      end else if (flash_lit && tick) begin
        remain <= remain - ONE;
        if (remain == ONE) begin
          flash_kill <= 1'b1;
          expire     <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fm_mode_decode.sv
module fm_mode_decode
  import fm_pkg::*;
(
  input  logic [3:0] ctl,
  input  logic       cmd_seen,
  input  logic       flash_kill,
  input  logic       torch_kill,
  input  logic       force_ready,
  input  logic       trig_pin,
  input  logic       time_left,
  output fm_mode_e   mode,
  output logic       ntc_en
);
  logic pwr, trig_eff, tch_eff;

  always_comb begin
    pwr      = cmd_seen & ctl[CTL_PWR];
    trig_eff = ctl[CTL_TRIG] & ~flash_kill & ~force_ready;
    tch_eff  = ctl[CTL_TCH] & ~torch_kill & ~force_ready;
    if (!pwr)                mode = MODE_OFF;
    else if (ctl[CTL_TRIG] && trig_eff)
      mode = (trig_pin && time_left) ? MODE_FLASH : MODE_IDLE;
    else if (tch_eff)        mode = MODE_TORCH;
    else                     mode = MODE_IDLE;
    ntc_en = (mode == MODE_TORCH) || (mode == MODE_FLASH) ||
             (cmd_seen && ctl[CTL_NTC]);
  end
endmodule

// File: rtl/fm_step_sel.sv
module fm_step_sel
  import fm_pkg::*;
#(
  parameter int DW   = 3,
  parameter int SW   = 4,
  parameter int FOFF = 5
) (
  input  fm_mode_e       mode,
  input  logic [DW-1:0]  tdim,
  input  logic [DW-1:0]  fdim,
  output logic [SW-1:0]  step
);
  always_comb begin
    case (mode)
      MODE_TORCH: step = SW'(tdim);
      MODE_FLASH: step = SW'(fdim) + SW'(FOFF);
      default:    step = '0;
    endcase
  end
endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
  import fm_pkg::*;
#(
  parameter int FTIM_W = 4,
  parameter int DIM_W  = 3,
  parameter int STEP_W = 4,
  parameter int FLASH_OFFSET = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [FTIM_W+3:0]     cmd_val,
  input  logic                  cmd_wr,
  input  logic [DIM_W-1:0]      tdim_val,
  input  logic [DIM_W-1:0]      fdim_val,
  input  logic                  trig_pin,
  input  logic                  tick_100ms,
  input  logic                  force_ready,
  output logic [1:0]            mode,
  output logic [STEP_W-1:0]     step_idx,
  output logic                  ntc_en,
  output logic                  timeout_evt,
  output logic                  clr_trig_en,
  output logic                  clr_dim_aux
);
  localparam int CMD_W = FTIM_W + 4;

  logic [FTIM_W-1:0] t_remain;
  logic              flash_kill, torch_kill, cmd_seen, expire;
  fm_mode_e          mode_e;

  fm_flash_timer #(.TW(FTIM_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .ftim       (cmd_val[FTIM_W-1:0]),
    .force_ready(force_ready),
    .tick       (tick_100ms),
    .flash_lit  (mode_e == MODE_FLASH),
    .remain     (t_remain),
    .flash_kill (flash_kill),
    .torch_kill (torch_kill),
    .cmd_seen   (cmd_seen),
    .expire     (expire)
  );

  fm_mode_decode u_decode (
    .ctl        (cmd_val[CMD_W-1 -: 4]),
    .cmd_seen   (cmd_seen),
    .flash_kill (flash_kill),
    .torch_kill (torch_kill),
    .force_ready(force_ready),
    .trig_pin   (trig_pin),
    .time_left  (|t_remain),
    .mode       (mode_e),
    .ntc_en     (ntc_en)
  );

  fm_step_sel #(.DW(DIM_W), .SW(STEP_W), .FOFF(FLASH_OFFSET)) u_step (
    .mode (mode_e),
    .tdim (tdim_val),
    .fdim (fdim_val),
    .step (step_idx)
  );

  assign mode        = mode_e;
  assign timeout_evt = expire;
  assign clr_trig_en = expire;
  assign clr_dim_aux = (mode_e == MODE_OFF);
endmodule

// File: rtl/fm_ctrl_checker.sv
module fm_ctrl_checker #(
  parameter int TW = 4,
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig_pin,
  input logic          cmd_wr,
  input logic          force_ready,
  input logic [1:0]    mode,
  input logic [SW-1:0] step_idx,
  input logic          ntc_en,
  input logic          timeout_evt,
  input logic          clr_dim_aux,
  input logic [TW-1:0] remain
);
  a_r2_flash_needs_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> trig_pin);

  a_r4_no_flash_without_budget: assert property (@(posedge clk) disable iff (!rst_n)
    (remain == '0) |-> (mode != 2'd3));

  a_r5_expiry_leaves_flash: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |-> (mode != 2'd3));

  a_r5_expiry_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> !timeout_evt);

  a_r6_budget_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_pin && !cmd_wr) |=> $stable(remain));

  a_r8_divider_when_lit: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'd2) || (mode == 2'd3)) |-> ntc_en);

  a_r11_force_dark: assert property (@(posedge clk) disable iff (!rst_n)
    force_ready |-> ((mode != 2'd2) && (mode != 2'd3)));

  a_r3_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (clr_dim_aux && (step_idx == '0)));
endmodule

bind flash_mode_ctrl fm_ctrl_checker #(.TW(FTIM_W), .SW(STEP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trig_pin   (trig_pin),
  .cmd_wr     (cmd_wr),
  .force_ready(force_ready),
  .mode       (mode),
  .step_idx   (step_idx),
  .ntc_en     (ntc_en),
  .timeout_evt(timeout_evt),
  .clr_dim_aux(clr_dim_aux),
  .remain     (t_remain)
);

// File: tb/flash_mode_ctrl_bench.sv
module flash_mode_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cmd_val = 8'hB0;
  logic       cmd_wr = 1'b0;
  logic [2:0] tdim_val = '0, fdim_val = '0;
  logic       trig_pin = 1'b0, tick_100ms = 1'b0, force_ready = 1'b0;
  logic [1:0] mode;
  logic [3:0] step_idx;
  logic       ntc_en, timeout_evt, clr_trig_en, clr_dim_aux;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_mode_ctrl u_flash_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_val(cmd_val), .cmd_wr(cmd_wr),
    .tdim_val(tdim_val), .fdim_val(fdim_val), .trig_pin(trig_pin),
    .tick_100ms(tick_100ms), .force_ready(force_ready), .mode(mode),
    .step_idx(step_idx), .ntc_en(ntc_en), .timeout_evt(timeout_evt),
    .clr_trig_en(clr_trig_en), .clr_dim_aux(clr_dim_aux)
  );

  // {cmd[7:0], pin, tdim[2:0], fdim[2:0], exp_mode[1:0], exp_step[3:0], exp_ntc}
  localparam logic [21:0] VEC [11] = '{
    {8'h00, 1'b0, 3'd0, 3'd0, 2'd0, 4'd0,  1'b0},
    {8'h10, 1'b0, 3'd0, 3'd0, 2'd0, 4'd0,  1'b1},
    {8'h80, 1'b0, 3'd5, 3'd5, 2'd1, 4'd0,  1'b0},
    {8'h90, 1'b0, 3'd0, 3'd0, 2'd1, 4'd0,  1'b1},
    {8'hA0, 1'b0, 3'd3, 3'd6, 2'd2, 4'd3,  1'b1},
    {8'hB0, 1'b1, 3'd7, 3'd0, 2'd2, 4'd7,  1'b1},
    {8'hC7, 1'b1, 3'd1, 3'd7, 2'd3, 4'd12, 1'b1},
    {8'hC7, 1'b0, 3'd1, 3'd2, 2'd1, 4'd0,  1'b0},
    {8'hE5, 1'b1, 3'd6, 3'd0, 2'd3, 4'd5,  1'b1},
    {8'hC0, 1'b1, 3'd0, 3'd3, 2'd1, 4'd0,  1'b0},
    {8'h70, 1'b1, 3'd0, 3'd0, 2'd0, 4'd0,  1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmd_write(input logic [7:0] v);
    @(negedge clk);
    cmd_val = v;
    cmd_wr  = 1'b1;
    @(negedge clk);
    cmd_wr  = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk);
    tick_100ms = 1'b1;
    @(negedge clk);
    tick_100ms = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: off after reset until first write, despite a torch command value
    check("R3 reset mode", mode, 0);
    check("R3 reset clear", clr_dim_aux, 1);
    check("R3 reset step", step_idx, 0);
    check("R5 reset no expiry", timeout_evt, 0);
    check("R8 reset divider", ntc_en, 0);

    // R1 R2 R8 R9: decode table
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      trig_pin = VEC[i][13];
      tdim_val = VEC[i][12:10];
      fdim_val = VEC[i][9:7];
      cmd_write(VEC[i][21:14]);
      check($sformatf("R1 mode vec%0d", i), mode, VEC[i][6:5]);
      check($sformatf("R9 step vec%0d", i), step_idx, VEC[i][4:1]);
      check($sformatf("R8 divider vec%0d", i), ntc_en, VEC[i][0]);
    end
    check("R3 off clears", clr_dim_aux, 1);

    // R4 R5: budget of 3 ticks
    trig_pin = 1'b1; fdim_val = 3'd2;
    cmd_write(8'hC3);
    check("R4 flash lit", mode, 3);
    tick_once(); tick_once();
    check("R4 lit after 2 ticks", mode, 3);
    check("R4 no early expiry", timeout_evt, 0);
    tick_once();
    check("R5 expiry pulse", timeout_evt, 1);
    check("R5 clear trig", clr_trig_en, 1);
    check("R5 flash ended", mode, 1);
    @(negedge clk);
    check("R5 pulse one cycle", timeout_evt, 0);
    check("R5 stays dark", mode, 1);

    // R6: pause while pin low
    cmd_write(8'hC2);
    tick_once();
    check("R6 lit before pause", mode, 3);
    trig_pin = 1'b0;
    @(negedge clk);
    check("R2 pin low idle", mode, 1);
    for (int k = 0; k < 3; k++) begin
      tick_once();
      check("R6 no expiry while paused", timeout_evt, 0);
    end
    trig_pin = 1'b1;
    @(negedge clk);
    check("R6 resumes lit", mode, 3);
    tick_once();
    check("R6 expiry after resume", timeout_evt, 1);

    // R7: reload extends and revives
    cmd_write(8'hC2);
    tick_once();
    cmd_write(8'hC2);
    tick_once();
    check("R7 extended still lit", mode, 3);
    check("R7 no expiry when extended", timeout_evt, 0);
    tick_once();
    check("R7 expiry after extension", timeout_evt, 1);
    cmd_write(8'hC2);
    check("R7 revived after expiry", mode, 3);

    // R5: expiry falls to torch when torch-on is set
    tdim_val = 3'd4; fdim_val = 3'd1;
    cmd_write(8'hE1);
    check("R9 flash step", step_idx, 6);
    tick_once();
    check("R5 expiry to torch", mode, 2);
    check("R9 torch step after expiry", step_idx, 4);

    // R10: torch unlimited, off by writing torch-on 0
    trig_pin = 1'b0;
    cmd_write(8'hA0);
    for (int k = 0; k < 20; k++) tick_once();
    check("R10 torch survives ticks", mode, 2);
    cmd_write(8'h80);
    check("R10 torch off to idle", mode, 1);

    // R11: forced idle
    cmd_write(8'hA0);
    @(negedge clk);
    force_ready = 1'b1;
    #1;
    check("R11 torch dark during force", mode, 1);
    @(negedge clk);
    force_ready = 1'b0;
    #1;
    check("R11 torch stays dark", mode, 1);
    cmd_write(8'hA0);
    check("R11 torch back after write", mode, 2);
    trig_pin = 1'b1;
    cmd_write(8'hC5);
    @(negedge clk);
    force_ready = 1'b1;
    #1;
    check("R11 flash dark during force", mode, 1);
    @(negedge clk);
    force_ready = 1'b0;
    for (int k = 0; k < 6; k++) tick_once();
    check("R11 flash stays dark", mode, 1);
    check("R11 no expiry while forced", timeout_evt, 0);

    // R3: write to off
    trig_pin = 1'b0;
    cmd_write(8'h20);
    check("R3 off after write", mode, 0);
    check("R3 clear level", clr_dim_aux, 1);
    check("R8 off divider", ntc_en, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule